// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns one memory request per machine cycle from an 8-bit core into the pin activity of a multiplexed external bus. Each machine cycle is split into a fixed number of base-clock ticks. An address-latch strobe pulses at the start of every cycle. The low address byte is placed on the shared byte-wide bus port, and the upper address nibble goes on a separate 4-bit port. After that the cycle runs as one of three kinds: an instruction fetch under the program strobe, a data read under the read strobe, or a data write under the write strobe. All three strobes are active low.

The block keeps its own register for the value the core last wrote to the bus port. That value is separate from the address path. It is put back onto the bus around each rising edge of the latch strobe, so port output stays usable while instructions are being fetched from outside. When the external-access input is low, a fetch request is served internally and leaves the bus as it would be in an idle cycle.

Top module: `ebs_bus_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `psen_n`, `rd_n` and `wr_n` are high, `rsp_valid` is low, `p2_oe` is low, and the bus drives the cleared port register (0x00) with `bus_oe` high.
- R2: A machine cycle is 15 ticks, numbered 0 to 14. `ale` is high on ticks 0 to 3 of every cycle, whatever kind of cycle it is.
- R3: In an external cycle (fetch, read or write), `bus_out` carries address bits 7..0 with `bus_oe` high on ticks 1 to 5. `p2_out` carries address bits 11..8 with `p2_oe` high on ticks 1 to 14. In all other cases `p2_out` is 0 and `p2_oe` is low.
- R4: An external fetch pulls `psen_n` low on ticks 7 to 12 and floats the bus (`bus_oe` low) on ticks 6 to 12. The value of `bus_in` at the end of tick 12 is returned on `rsp_data`, with `rsp_valid` high during tick 13 only.
- R5: A read pulls `rd_n` low on ticks 6 to 12 and floats the bus on ticks 6 to 12. The value of `bus_in` at the end of tick 12 is returned in the same way as for a fetch.
- R6: A write drives the write data on the bus with `bus_oe` high on ticks 6 to 14 and pulls `wr_n` low on ticks 7 to 13. A write produces no response.
- R7: The bus-port register is driven on the bus with `bus_oe` high in these places: tick 0 of every cycle, ticks 13 and 14 of fetch and read cycles, and every tick of an idle cycle.
- R8: A fetch request taken while `ext_access` is low runs as an idle cycle. It asserts no strobe, drives no `p2` address and raises no `rsp_valid`.
- R9: `req_ready` is high during tick 14 only. A request present at the clock edge that ends tick 14 runs in the next cycle. The `req_kind` codes are 0 idle, 1 fetch, 2 read and 3 write. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and none is low while `ale` is high.
- R10: A pulse on `port_wr_en` updates the bus-port register at that clock edge, even in the middle of external cycles. The new value appears in the next bus-port window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_access | input | 1 | High: fetches go to the external bus |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | 0 idle, 1 fetch, 2 read, 3 write |
| req_addr | input | 12 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | High in the last tick; request taken at its end |
| rsp_valid | output | 1 | One-tick pulse with fetched or read byte |
| rsp_data | output | 8 | Captured byte |
| port_wr_en | input | 1 | Load the bus-port register |
| port_wr_data | input | 8 | New bus-port value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| bus_out | output | 8 | Bus port output value |
| bus_oe | output | 1 | Bus port drive enable |
| bus_in | input | 8 | Bus port input value |
| p2_out | output | 4 | Upper address nibble |
| p2_oe | output | 1 | Drive enable for the upper nibble |

## Verification
The bench places an external memory model on the pins. The model latches the low address on the falling edge of `ale` and answers only while a strobe is low. A strobe window that is off by one tick therefore returns the filler byte in place of the addressed byte. Back-to-back cycles of mixed kinds exercise the window where a write's data turns into the port value at tick 0, and the turnaround from a float to a driven bus. A port write landing inside an external fetch checks that the restored value is the new one, not the stale address. Addresses 0x000 and 0xFFF and data 0x00 and 0xFF expose swapped or truncated nibble and byte lanes. An internal fetch taken with `ext_access` low catches a design that still issues `psen_n`.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FETCH = 2'd1,
      OP_READ  = 2'd2,
      OP_WRITE = 2'd3
   } ebs_op_e;
endpackage

// File: rtl/ebs_tick_counter.sv
module ebs_tick_counter #(
   parameter int TICKS = 15,
   localparam int CW = $clog2(TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] tick,
   output logic          last
);
   localparam logic [CW-1:0] LAST_TICK = CW'(TICKS - 1);

   if (TICKS < 8) begin : g_bad_ticks
      $error("ebs_tick_counter: TICKS too small");
   end

   assign last = (tick == LAST_TICK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tick <= '0;
      else if (last) tick <= '0;
      else           tick <= tick + 1'b1;
   end

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tick <= LAST_TICK);  // R2
endmodule

// File: rtl/ebs_strobe_decode.sv
module ebs_strobe_decode
   import ebs_pkg::*;
#(
   parameter int TICKS    = 15,
   parameter int ALE_LEN  = 4,
   parameter int ADDR_LEN = 5,
   parameter int PSEN_LEN = 6,
   parameter int RDWR_LEN = 7,
   localparam int CW      = $clog2(TICKS)
) (
   input  logic [CW-1:0] tick,
   input  ebs_op_e       op,
   output logic          ale,
   output logic          addr_ph,
   output logic          wdata_ph,
   output logic          float_ph,
   output logic          p2_ph,
   output logic          sample,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n
);
   localparam int DATA_S = ADDR_LEN + 1;
   localparam int SAMPLE = ADDR_LEN + RDWR_LEN;
   localparam int PSEN_S = SAMPLE - PSEN_LEN + 1;
   localparam int WR_S   = DATA_S + 1;
   localparam int WR_E   = WR_S + RDWR_LEN - 1;
   localparam int NWIN   = 6;
   // window order: address, psen, rd, wr, float, write data
   localparam int WIN_LO [NWIN] = '{1, PSEN_S, DATA_S, WR_S, DATA_S, DATA_S};
   localparam int WIN_HI [NWIN] = '{ADDR_LEN, SAMPLE, SAMPLE, WR_E, SAMPLE, TICKS - 1};

   if (ALE_LEN < 2 || ALE_LEN > ADDR_LEN) begin : g_bad_ale
      $error("ebs_strobe_decode: ALE must fall inside the address phase");
   end
   if (WR_E > TICKS - 2 || SAMPLE > TICKS - 3) begin : g_bad_len
      $error("ebs_strobe_decode: strobe phases exceed the machine cycle");
   end
   if (PSEN_S <= ADDR_LEN) begin : g_bad_psen
      $error("ebs_strobe_decode: program strobe overlaps the address phase");
   end

   logic [NWIN-1:0] win;
   for (genvar g = 0; g < NWIN; g++) begin : g_win
      assign win[g] = (tick >= CW'(WIN_LO[g])) && (tick <= CW'(WIN_HI[g]));
   end

   logic ext, is_f, is_r, is_w;
   assign is_f = (op == OP_FETCH);
   assign is_r = (op == OP_READ);
   assign is_w = (op == OP_WRITE);
   assign ext  = is_f | is_r | is_w;

   assign ale      = (tick < CW'(ALE_LEN));
   assign addr_ph  = ext & win[0];
   assign psen_n   = ~(is_f & win[1]);
   assign rd_n     = ~(is_r & win[2]);
   assign wr_n     = ~(is_w & win[3]);
   assign float_ph = (is_f | is_r) & win[4];
   assign wdata_ph = is_w & win[5];
   assign p2_ph    = ext & (tick != '0);
   assign sample   = (is_f | is_r) & (tick == CW'(SAMPLE));
endmodule

// File: rtl/ebs_bus_datapath.sv
module ebs_bus_datapath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_wr_en,
   input  logic [DATA_W-1:0] port_wr_data,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wdata,
   input  logic              addr_ph,
   input  logic              wdata_ph,
   input  logic              float_ph,
   input  logic              sample,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   logic [DATA_W-1:0] port_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          port_q <= '0;
      else if (port_wr_en) port_q <= port_wr_data;
   end

   always_comb begin
      bus_oe  = 1'b1;
      bus_out = port_q;
      if (addr_ph)       bus_out = addr_lo;
      else if (wdata_ph) bus_out = wdata;
      else if (float_ph) bus_oe  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= sample;
         if (sample) rsp_data <= bus_in;
      end
   end

   AST_FLOAT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      float_ph |-> !bus_oe);  // R5
endmodule

// File: rtl/ebs_bus_sequencer.sv
module ebs_bus_sequencer
   import ebs_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_HI_W = 4,
   parameter int TICKS     = 15,
   parameter int ALE_LEN   = 4,
   parameter int ADDR_LEN  = 5,
   parameter int PSEN_LEN  = 6,
   parameter int RDWR_LEN  = 7,
   localparam int ADDR_W   = DATA_W + ADDR_HI_W,
   localparam int CW       = $clog2(TICKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ext_access,
   input  logic                 req_valid,
   input  logic [1:0]           req_kind,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 req_ready,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_data,
   input  logic                 port_wr_en,
   input  logic [DATA_W-1:0]    port_wr_data,
   output logic                 ale,
   output logic                 psen_n,
   output logic                 rd_n,
   output logic                 wr_n,
   output logic [DATA_W-1:0]    bus_out,
   output logic                 bus_oe,
   input  logic [DATA_W-1:0]    bus_in,
   output logic [ADDR_HI_W-1:0] p2_out,
   output logic                 p2_oe
);
   logic [CW-1:0]     tick;
   logic              last;
   ebs_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic addr_ph, wdata_ph, float_ph, p2_ph, sample;

   ebs_tick_counter #(.TICKS(TICKS)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick), .last(last));

   // request taken at the edge ending the last tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (last) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         if (!req_valid)
            op_q <= OP_IDLE;
         else if (ebs_op_e'(req_kind) == OP_FETCH && !ext_access)
            op_q <= OP_IDLE;
         else
            op_q <= ebs_op_e'(req_kind);
      end
   end

   assign req_ready = last;

   ebs_strobe_decode #(
      .TICKS(TICKS), .ALE_LEN(ALE_LEN), .ADDR_LEN(ADDR_LEN),
      .PSEN_LEN(PSEN_LEN), .RDWR_LEN(RDWR_LEN)
   ) u_dec (
      .tick(tick), .op(op_q), .ale(ale), .addr_ph(addr_ph),
      .wdata_ph(wdata_ph), .float_ph(float_ph), .p2_ph(p2_ph),
      .sample(sample), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n));

   ebs_bus_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .port_wr_en(port_wr_en),
      .port_wr_data(port_wr_data), .addr_lo(addr_q[DATA_W-1:0]),
      .wdata(wdata_q), .addr_ph(addr_ph), .wdata_ph(wdata_ph),
      .float_ph(float_ph), .sample(sample), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data));

   assign p2_oe  = p2_ph;
   assign p2_out = p2_ph ? addr_q[ADDR_W-1:DATA_W] : '0;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);  // R9
   AST_NO_STROBE_IN_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (psen_n && rd_n && wr_n));  // R9
   AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!psen_n || !rd_n));  // R4
   AST_WR_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> bus_oe);  // R6
   AST_ALE_PULSE_EACH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> ale);  // R2
   AST_P2_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !p2_oe |-> (p2_out == '0));  // R3
endmodule

// File: tb/ebs_bus_sequencer_tb.sv
module ebs_bus_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_access = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [11:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        port_wr_en = 1'b0;
   logic [7:0]  port_wr_data = '0;
   logic        req_ready, rsp_valid, ale, psen_n, rd_n, wr_n, bus_oe, p2_oe;
   logic [7:0]  rsp_data, bus_out, bus_in;
   logic [3:0]  p2_out;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   ebs_bus_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .ext_access(ext_access),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .port_wr_en(port_wr_en),
      .port_wr_data(port_wr_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
      .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
      .p2_out(p2_out), .p2_oe(p2_oe));

   function automatic logic [7:0] mem_byte(input logic [11:0] a);
      return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h96;
   endfunction

   // external memory: low address latched on ALE fall, answers under a strobe
   logic [7:0] lo_q = '0;
   always @(negedge ale) lo_q = bus_out;
   assign bus_in = (!rd_n || !psen_n) ? mem_byte({p2_out, lo_q}) : 8'hEE;

   // behavioural reference: 0 idle, 1 fetch, 2 read, 3 write
   int         m_t = 0;
   int         m_op = 0;
   logic [11:0] m_addr = '0;
   logic [7:0]  m_wd = '0, m_port = '0, m_rd = '0;
   logic        m_rv = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_t = 0; m_op = 0; m_addr = '0; m_wd = '0; m_port = '0;
         m_rd = '0; m_rv = 1'b0;
      end else begin
         if (m_t == 12 && (m_op == 1 || m_op == 2)) begin
            m_rv = 1'b1; m_rd = mem_byte(m_addr);
         end else m_rv = 1'b0;
         if (port_wr_en) m_port = port_wr_data;
         if (m_t == 14) begin
            m_addr = req_addr; m_wd = req_wdata;
            if (!req_valid) m_op = 0;
            else if (req_kind == 2'd1 && !ext_access) m_op = 0;
            else m_op = int'(req_kind);
            m_t = 0;
         end else m_t = m_t + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (tick %0d op %0d)", tag, act, exp, m_t, m_op);
      end
   endtask

   always @(negedge clk) begin
      logic e_ale, e_ps, e_rd, e_wr, e_oe, e_p2oe, drive_chk;
      logic [7:0] e_bus;
      logic [3:0] e_p2;
      logic ext;
      cycles++;
      ext    = (m_op != 0);
      e_ale  = (m_t <= 3);
      e_ps   = !(m_op == 1 && m_t >= 7 && m_t <= 12);
      e_rd   = !(m_op == 2 && m_t >= 6 && m_t <= 12);
      e_wr   = !(m_op == 3 && m_t >= 7 && m_t <= 13);
      e_p2oe = ext && m_t >= 1;
      e_p2   = e_p2oe ? m_addr[11:8] : 4'h0;
      e_oe = 1'b1; drive_chk = 1'b1; e_bus = m_port;
      if (ext && m_t >= 1 && m_t <= 5) e_bus = m_addr[7:0];
      else if (m_op == 3 && m_t >= 6) e_bus = m_wd;
      else if ((m_op == 1 || m_op == 2) && m_t >= 6 && m_t <= 12) begin
         e_oe = 1'b0; drive_chk = 1'b0;
      end
      chk("R2 ale", ale, e_ale);
      chk("R4 psen_n", psen_n, e_ps);
      chk("R5 rd_n", rd_n, e_rd);
      chk("R6 wr_n", wr_n, e_wr);
      chk("R3/R7 bus_oe", bus_oe, e_oe);
      if (drive_chk) chk("R3/R6/R7 bus_out", bus_out, e_bus);
      chk("R3 p2_oe", p2_oe, e_p2oe);
      chk("R3 p2_out", p2_out, e_p2);
      chk("R9 req_ready", req_ready, (m_t == 14));
      chk("R4/R5 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R4/R5 rsp_data", rsp_data, m_rd);
   end

   task automatic finish_up();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) if (cycles > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   task automatic do_req(input logic [1:0] kind, input logic [11:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = d;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; req_kind = 2'd0;
   endtask

   task automatic port_write(input logic [7:0] d);
      @(posedge clk); #1;
      port_wr_en = 1'b1; port_wr_data = d;
      @(posedge clk); #1;
      port_wr_en = 1'b0;
   endtask

   task automatic idle_cycle();
      repeat (15) @(posedge clk);
   endtask

   initial begin
      int psen_lows;
      repeat (4) @(posedge clk);
      // R1: reset state seen at the pins
      @(negedge clk);
      chk("R1 psen_n", psen_n, 1'b1);
      chk("R1 rd_n", rd_n, 1'b1);
      chk("R1 wr_n", wr_n, 1'b1);
      chk("R1 rsp_valid", rsp_valid, 1'b0);
      chk("R1 p2_oe", p2_oe, 1'b0);
      chk("R1 bus", {bus_oe, bus_out}, 9'h100);
      #1 rst_n = 1'b1;
      idle_cycle();
      port_write(8'hA5);
      do_req(2'd1, 12'h123, 8'h00);
      do_req(2'd1, 12'hFFF, 8'h00);
      do_req(2'd2, 12'h0AB, 8'h00);
      do_req(2'd3, 12'h5C0, 8'h3E);
      do_req(2'd1, 12'h000, 8'h00);
      // R10: port value rewritten during an external fetch
      fork
         do_req(2'd1, 12'h7E4, 8'h00);
         begin repeat (20) @(posedge clk); port_write(8'h5A); end
      join
      do_req(2'd2, 12'hFFF, 8'h00);
      do_req(2'd3, 12'hFFF, 8'hFF);
      do_req(2'd3, 12'h000, 8'h00);
      idle_cycle();
      @(negedge clk);
      while (m_t != 0) @(negedge clk);
      chk("R10 port restored at tick 0", {bus_oe, bus_out}, 9'h15A);
      // R8: fetch with ext_access low must not touch the bus
      ext_access = 1'b0;
      psen_lows = 0;
      fork
         do_req(2'd1, 12'h321, 8'h00);
         repeat (40) begin @(negedge clk); if (!psen_n || p2_oe || rsp_valid) psen_lows++; end
      join
      chk("R8 internal fetch bus activity", psen_lows, 0);
      ext_access = 1'b1;
      do_req(2'd2, 12'h800, 8'h00);
      do_req(2'd0, 12'h800, 8'h00);
      idle_cycle();
      idle_cycle();
      finish_up();
   end
endmodule